// File: doc/BRIEF.md
# Region-Speculative Store Buffer

This block sits between an in-order core and a slow non-volatile memory. Every store the core commits is held in a small circular buffer and treated as speculative. Nothing reaches memory until the core marks the end of a code region. At that boundary, all stores buffered so far become released. They then drain to memory, oldest first, one write per accepted handshake. While that drain runs, the core keeps storing into the buffer for the next region, so memory writes overlap with speculative execution.

A power-fail input drops every buffered entry in a single cycle, including released entries not yet written. Memory therefore keeps the state of the last region whose drain finished. A load-lookup port lets the core read its own buffered stores: the youngest matching entry from either region is returned ahead of memory data. A drained output tells software when a checkpoint has fully persisted.

The store port and the memory write port are valid/ready.
- The store port lowers `st_ready` when the buffer is full. Regions are sized so that this never happens in correct operation.
- The memory port holds `mem_valid`, `mem_addr` and `mem_data` steady until `mem_ready` is seen.
- The region-end request is also valid/ready. It is refused while a released region is still draining, which stalls the core.

Top module: `rspec_store_buf`

## Requirements
- R1: A store accepted on the store port is buffered and is not offered on the memory port (`mem_valid` stays 0) until a region end covering it has been accepted.
- R2: An accepted region end (`end_valid` and `end_ready` high at a clock edge) releases exactly the entries held before that edge. A store accepted at the same edge belongs to the next region.
- R3: Released entries leave in store order, oldest first, one per edge with `mem_valid` and `mem_ready` both high. While `mem_ready` is low, `mem_valid`, `mem_addr` and `mem_data` hold steady.
- R4: Stores are accepted while a released region drains, and they are not released by that drain.
- R5: `end_ready` is 0 whenever any released entry remains, so a second region end stalls until the drain finishes.
- R6: `st_ready` is 0 exactly when DEPTH entries are held, counting released and speculative entries together.
- R7: `ld_hit` is 1 when any held entry has address `ld_addr`, and `ld_data` is then the data of the youngest such entry. `ld_hit` is 0 when no held entry matches.
- R8: With `pwr_fail` high at an edge, every entry is discarded, including released ones, and all other inputs at that edge are ignored. During that cycle `mem_valid` is 0.
- R9: `drained` is 1 exactly when no released entry remains.
- R10: After reset the buffer is empty: `st_ready`=1, `mem_valid`=0, `end_ready`=1, `drained`=1, `ld_hit`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_fail | input | 1 | Power-loss indication; discards all entries |
| st_valid | input | 1 | Core offers a committed store |
| st_ready | output | 1 | Buffer can take a store |
| st_addr | input | AW | Store address |
| st_data | input | DW | Store data |
| end_valid | input | 1 | Core requests a region boundary |
| end_ready | output | 1 | Boundary accepted this cycle if requested |
| ld_addr | input | AW | Load lookup address |
| ld_hit | output | 1 | A buffered store matches `ld_addr` |
| ld_data | output | DW | Data of the youngest matching store |
| mem_valid | output | 1 | A released entry is offered to memory |
| mem_ready | input | 1 | Memory takes the offered write |
| mem_addr | output | AW | Write address to memory |
| mem_data | output | DW | Write data to memory |
| drained | output | 1 | No released entry remains |

## Verification
The assertions watch several rules on every cycle:
- the released count never exceeds the held count;
- the number of set valid bits equals the held count;
- a stalled memory write holds steady;
- a power failure leaves an empty, drained buffer;
- the core never offers a store to a full buffer.

Other behaviours can only be shown by the bench's scenarios, which compare against a reference queue:
- write order;
- the split between the released region and the speculative region when a store and a region end share an edge;
- youngest-match forwarding across both regions;
- the absence of any stale write after a power failure.

// File: rtl/rsb_pkg.sv
package rsb_pkg;
  localparam int DEF_DEPTH = 8;
  localparam int DEF_AW    = 16;
  localparam int DEF_DW    = 32;
endpackage

// File: rtl/rsb_ctrl.sv
module rsb_ctrl #(
  parameter int DEPTH = 8,
  parameter int PW    = $clog2(DEPTH),
  parameter int CW    = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_fail,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic          end_valid,
  output logic          end_ready,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic          push,
  output logic          pop,
  output logic [PW-1:0] head,
  output logic [PW-1:0] tail,
  output logic [CW-1:0] count,
  output logic          drained
);
  logic [CW-1:0] rel_cnt;
  logic          take_end;

  assign st_ready  = (count != CW'(DEPTH));
  assign end_ready = (rel_cnt == '0);
  assign drained   = (rel_cnt == '0);
  assign mem_valid = (rel_cnt != '0) && !pwr_fail;
  assign push      = st_valid && st_ready && !pwr_fail;
  assign pop       = mem_valid && mem_ready;
  assign take_end  = end_valid && end_ready && !pwr_fail;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head    <= '0;
      tail    <= '0;
      count   <= '0;
      rel_cnt <= '0;
    end else if (pwr_fail) begin
      tail    <= head;
      count   <= '0;
      rel_cnt <= '0;
    end else begin
      if (push) tail <= tail + 1'b1;
      if (pop)  head <= head + 1'b1;
      count <= count + CW'(push) - CW'(pop);
      if (take_end)  rel_cnt <= count;
      else if (pop)  rel_cnt <= rel_cnt - 1'b1;
    end
  end

  // R2: released entries are always a subset of the held ones
  p_rel_in_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rel_cnt <= count);

  // R8: a power failure leaves nothing held and nothing released
  p_pfail_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> (count == '0) && drained);

  // R6: the core never offers a store into a full buffer
  p_no_overflow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid |-> st_ready);
endmodule

// File: rtl/rsb_entries.sv
module rsb_entries #(
  parameter int DEPTH = 8,
  parameter int AW    = 16,
  parameter int DW    = 32,
  parameter int PW    = $clog2(DEPTH),
  parameter int CW    = PW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_fail,
  input  logic          push,
  input  logic          pop,
  input  logic [PW-1:0] head,
  input  logic [PW-1:0] tail,
  input  logic [CW-1:0] count,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic [AW-1:0] head_addr,
  output logic [DW-1:0] head_data
);
  logic [AW-1:0]    addr_q [DEPTH];
  logic [DW-1:0]    data_q [DEPTH];
  logic [DEPTH-1:0] vld_q;

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        vld_q[g]  <= 1'b0;
        addr_q[g] <= '0;
        data_q[g] <= '0;
      end else if (pwr_fail) begin
        vld_q[g] <= 1'b0;
      end else if (push && tail == PW'(g)) begin
        vld_q[g]  <= 1'b1;
        addr_q[g] <= wr_addr;
        data_q[g] <= wr_data;
      end else if (pop && head == PW'(g)) begin
        vld_q[g] <= 1'b0;
      end
    end
  end

  assign head_addr = addr_q[head];
  assign head_data = data_q[head];

  // Walk oldest to youngest; a later match overrides an earlier one.
  always_comb begin
    ld_hit  = 1'b0;
    ld_data = '0;
    for (int k = 0; k < DEPTH; k++) begin
      logic [PW-1:0] idx;
      idx = head + PW'(k);
      if (CW'(k) < count && vld_q[idx] && addr_q[idx] == ld_addr) begin
        ld_hit  = 1'b1;
        ld_data = data_q[idx];
      end
    end
  end

  // R1: one valid bit per held entry
  p_valid_count_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(vld_q) == int'(count));
endmodule

// File: rtl/rspec_store_buf.sv
module rspec_store_buf #(
  parameter int DEPTH = rsb_pkg::DEF_DEPTH,
  parameter int AW    = rsb_pkg::DEF_AW,
  parameter int DW    = rsb_pkg::DEF_DW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pwr_fail,
  input  logic          st_valid,
  output logic          st_ready,
  input  logic [AW-1:0] st_addr,
  input  logic [DW-1:0] st_data,
  input  logic          end_valid,
  output logic          end_ready,
  input  logic [AW-1:0] ld_addr,
  output logic          ld_hit,
  output logic [DW-1:0] ld_data,
  output logic          mem_valid,
  input  logic          mem_ready,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_data,
  output logic          drained
);
  localparam int PW = $clog2(DEPTH);
  localparam int CW = PW + 1;

  logic          push, pop;
  logic [PW-1:0] head, tail;
  logic [CW-1:0] count;

  rsb_ctrl #(.DEPTH(DEPTH), .PW(PW), .CW(CW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
    .st_valid(st_valid), .st_ready(st_ready),
    .end_valid(end_valid), .end_ready(end_ready),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .push(push), .pop(pop), .head(head), .tail(tail),
    .count(count), .drained(drained)
  );

  rsb_entries #(.DEPTH(DEPTH), .AW(AW), .DW(DW), .PW(PW), .CW(CW)) u_ent (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
    .push(push), .pop(pop), .head(head), .tail(tail), .count(count),
    .wr_addr(st_addr), .wr_data(st_data), .ld_addr(ld_addr),
    .ld_hit(ld_hit), .ld_data(ld_data),
    .head_addr(mem_addr), .head_data(mem_data)
  );

  // R3: a stalled write keeps its content unless power fails
  p_mem_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_valid && !mem_ready) |=>
      (pwr_fail || (mem_valid && $stable(mem_addr) && $stable(mem_data))));
endmodule

// File: tb/rspec_store_buf_test.sv
`timescale 1ns/1ps
module rspec_store_buf_test;
  localparam int DEPTH = 4;
  localparam int AW = 3;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0, pwr_fail = 0;
  logic st_valid = 0, end_valid = 0, mem_ready = 0;
  logic [AW-1:0] st_addr = '0, ld_addr = '0;
  logic [DW-1:0] st_data = '0;
  logic st_ready, end_ready, ld_hit, mem_valid, drained;
  logic [DW-1:0] ld_data, mem_data;
  logic [AW-1:0] mem_addr;

  rspec_store_buf #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) uut (
    .clk(clk), .rst_n(rst_n), .pwr_fail(pwr_fail),
    .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr), .st_data(st_data),
    .end_valid(end_valid), .end_ready(end_ready),
    .ld_addr(ld_addr), .ld_hit(ld_hit), .ld_data(ld_data),
    .mem_valid(mem_valid), .mem_ready(mem_ready),
    .mem_addr(mem_addr), .mem_data(mem_data), .drained(drained));

  always #10 clk = ~clk;

  int checks = 0, fails = 0;
  int wr = 0, rd = 0, rel = 0;
  logic [AW-1:0] m_addr [0:4095];
  logic [DW-1:0] m_data [0:4095];
  int dseq = 1;
  int writes = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic check_outputs();
    bit eh; int ed;
    chk(st_ready == ((wr - rd) < DEPTH), "R6", st_ready, (wr - rd) < DEPTH);
    chk(mem_valid == (rel != 0 && !pwr_fail), "R1", mem_valid, rel != 0 && !pwr_fail);
    chk(end_ready == (rel == 0), "R5", end_ready, rel == 0);
    chk(drained == (rel == 0), "R9", drained, rel == 0);
    if (mem_valid && rel != 0) begin
      chk(mem_addr == m_addr[rd], "R3", mem_addr, m_addr[rd]);
      chk(mem_data == m_data[rd], "R3", mem_data, m_data[rd]);
    end
    eh = 0; ed = 0;
    for (int i = wr - 1; i >= rd; i--)
      if (!eh && m_addr[i] == ld_addr) begin eh = 1; ed = m_data[i]; end
    chk(ld_hit == eh, "R7", ld_hit, eh);
    if (eh) chk(ld_data == ed[DW-1:0], "R7", ld_data, ed);
  endtask

  // Inputs are already driven just after a negedge; sample, update model, advance.
  task automatic step();
    #5;
    check_outputs();
    if (pwr_fail) begin
      rd = wr; rel = 0;
    end else begin
      if (mem_ready && rel != 0) begin rd++; rel--; writes++; end
      else if (end_valid && rel == 0) rel = wr - rd;
      if (st_valid && (wr - rd) < DEPTH) begin
        m_addr[wr] = st_addr; m_data[wr] = st_data; wr++;
      end
    end
    @(negedge clk);
    ld_addr = ld_addr + 1'b1;
  endtask

  task automatic drive(input bit sv, input bit ev, input bit mr, input bit pf);
    st_valid = sv && ((wr - rd) < DEPTH);
    st_addr = AW'((dseq * 5) >> 1);
    st_data = DW'(dseq);
    if (st_valid) dseq++;
    end_valid = ev; mem_ready = mr; pwr_fail = pf;
    step();
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10: reset state
    chk(st_ready == 1 && mem_valid == 0 && end_ready == 1 && drained == 1 && ld_hit == 0,
        "R10", {st_ready, mem_valid, end_ready, drained, ld_hit}, 5'b10110);
    rst_n = 1;
    @(negedge clk);

    // Sweep: region size n, release pattern mp
    for (int n = 1; n <= DEPTH; n++) begin
      for (int mp = 0; mp < 3; mp++) begin
        for (int i = 0; i < n; i++) drive(1, 0, 1, 0);       // R1: no writes yet
        drive(0, 0, 1, 0);
        chk(writes == 0 || rel == 0, "R1", mem_valid, 0);
        drive(mp == 1, 1, 0, 0);                              // R2: same-edge store
        for (int t = 0; t < 30 && rel != 0; t++)              // R4/R5: overlap, stall
          drive(t % 2 == 0, 1, (mp != 2) || (t % 3 == 0), 0);
        for (int t = 0; t < 30 && (wr - rd) != 0; t++)
          drive(0, 1, 1, 0);
        end_valid = 0;
        chk(wr == rd && drained == 1, "R9", wr - rd, 0);
      end
    end

    // R8: power failure mid-drain discards released and speculative entries
    for (int pt = 0; pt < 3; pt++) begin
      drive(1, 0, 0, 0); drive(1, 0, 0, 0);
      drive(0, 1, 0, 0);
      drive(1, 0, pt == 1, 0); drive(1, 0, 0, 0);
      drive(pt == 2, pt == 2, 1, 1);
      for (int a = 0; a < (1 << AW); a++) begin
        ld_addr = AW'(a); #1;
        chk(ld_hit == 0, "R8", ld_hit, 0);
      end
      chk(mem_valid == 0 && drained == 1 && st_ready == 1, "R8",
          {mem_valid, drained, st_ready}, 3'b011);
      drive(1, 0, 1, 0); drive(0, 1, 1, 0);
      for (int t = 0; t < 10 && rel != 0; t++) drive(0, 0, 1, 0);
      chk(wr == rd, "R8", wr - rd, 0);
    end

    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule